// File: doc/BRIEF.md
# Endpoint Interrupt Aggregator with Isochronous-Incomplete Detection

This block collects interrupt events for the endpoints of a USB device controller: one bidirectional control endpoint (endpoint 0) and a configurable number of IN and OUT data endpoints, five of each by default. Each endpoint has a small set of event sources per direction. An event pulse latches a sticky status bit. Writing a 1 to that bit clears it. A single IN mask and a single OUT mask, each one bit per event source, gate that source on every endpoint of the direction, endpoint 0 included. The gated bits are reduced to one summary bit per endpoint and then to one interrupt line per direction.

The block also tracks frames. A start-of-frame strobe clears a per-endpoint "completed" bit, and a transfer-complete pulse sets it. When the end-of-periodic-frame strobe arrives, the block raises a sticky end-of-frame flag. In the same cycle it raises an incomplete-isochronous flag for each direction in which an enabled isochronous data endpoint has not completed its transfer during the frame.

Top module: `ep_irq_agg`

## Requirements
- R1: An event pulse on `in_evt`/`out_evt` bit i sets status bit i on the next clock edge. The bit stays set until cleared. After reset every status bit and flag is 0.
- R2: A 1 on `in_clr`/`out_clr` bit i clears status bit i on the next edge. If bit i has an event and a clear in the same cycle, the bit is set.
- R3: Status bit e*NEVT+k belongs to endpoint e (0 is the control endpoint) and event source k. The masked status output equals that bit ANDed with mask bit k. Masking hides a bit but does not clear it, so unmasking shows it again.
- R4: Summary bit e is the OR of endpoint e's masked status bits. `in_ep_irq`/`out_ep_irq` is the OR of all summary bits of that direction.
- R5: An `eof` pulse sets `eopf_flag` on the next edge.
- R6: On an `eof` pulse, `iso_in_incomp` is set on the same edge as `eopf_flag` if at least one enabled IN data endpoint of type isochronous has no completion recorded. Type encoding, 2 bits per data endpoint d (1..NDATA) at bits [2(d-1)+:2]: 00 control, 01 isochronous, 10 bulk, 11 interrupt.
- R7: The same rule applies to `iso_out_incomp` for OUT data endpoints.
- R8: Disabled endpoints and endpoints of bulk, interrupt or control type never cause an incomplete flag. Endpoint 0 never takes part in the check.
- R9: A transfer-complete pulse records completion for its endpoint, and `sof` erases it. A completion in the same cycle as `sof` survives. A completion in the same cycle as `eof` counts for that frame.
- R10: The three global flags are sticky and are cleared by writing 1 on `flag_clr` (bit 0 end-of-frame, bit 1 IN incomplete, bit 2 OUT incomplete). If a flag is set and cleared in the same cycle, it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_evt | input | (NDATA+1)*NEVT | IN event pulses, endpoint-major |
| out_evt | input | (NDATA+1)*NEVT | OUT event pulses, endpoint-major |
| in_clr | input | (NDATA+1)*NEVT | IN status write-1-to-clear |
| out_clr | input | (NDATA+1)*NEVT | OUT status write-1-to-clear |
| in_mask | input | NEVT | Common IN event-source mask |
| out_mask | input | NEVT | Common OUT event-source mask |
| in_ep_en | input | NDATA | IN data endpoint enables |
| out_ep_en | input | NDATA | OUT data endpoint enables |
| in_ep_type | input | 2*NDATA | IN data endpoint transfer types |
| out_ep_type | input | 2*NDATA | OUT data endpoint transfer types |
| in_xfer_done | input | NDATA | IN transfer-complete pulses |
| out_xfer_done | input | NDATA | OUT transfer-complete pulses |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-periodic-frame strobe |
| flag_clr | input | 3 | Global flag write-1-to-clear |
| in_status | output | (NDATA+1)*NEVT | Masked IN status |
| out_status | output | (NDATA+1)*NEVT | Masked OUT status |
| in_ep_sum | output | NDATA+1 | IN per-endpoint summary |
| out_ep_sum | output | NDATA+1 | OUT per-endpoint summary |
| in_ep_irq | output | 1 | Any IN endpoint interrupt |
| out_ep_irq | output | 1 | Any OUT endpoint interrupt |
| eopf_flag | output | 1 | Sticky end-of-periodic-frame flag |
| iso_in_incomp | output | 1 | Sticky incomplete isochronous IN flag |
| iso_out_incomp | output | 1 | Sticky incomplete isochronous OUT flag |

## Verification
The bench uses the default parameters: five data endpoints per direction and four event sources. This gives a 24-bit status vector per direction, so every endpoint position, endpoint 0 included, meets every mask bit. With five data endpoints the bench can mix isochronous, bulk, interrupt, control-typed and disabled endpoints in a single frame. It can also make start-of-frame, end-of-frame and completion pulses coincide, which exercises the ordering rules against a behavioural model on every clock.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
   typedef enum logic [1:0] {
      XT_CTRL = 2'b00,
      XT_ISOC = 2'b01,
      XT_BULK = 2'b10,
      XT_INTR = 2'b11
   } xfer_type_e;

   localparam int FLAG_EOPF    = 0;
   localparam int FLAG_ISO_IN  = 1;
   localparam int FLAG_ISO_OUT = 2;
   localparam int NUM_FLAGS    = 3;
endpackage

// File: rtl/ep_stat_bank.sv
module ep_stat_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] st_o
);
   if (W < 1) begin : g_bad_w
      $error("ep_stat_bank: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        st_o[i] <= 1'b0;
         else if (set_i[i]) st_o[i] <= 1'b1;
         else if (clr_i[i]) st_o[i] <= 1'b0;
      end
   end

   // R1
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((st_o & $past(set_i)) == $past(set_i)));

   // R2
   clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((st_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/ep_summary.sv
module ep_summary #(
   parameter int NUM_EP  = 6,
   parameter int NUM_EVT = 4
) (
   input  logic [NUM_EP*NUM_EVT-1:0] st_i,
   input  logic [NUM_EVT-1:0]        mask_i,
   output logic [NUM_EP*NUM_EVT-1:0] masked_o,
   output logic [NUM_EP-1:0]         sum_o,
   output logic                      any_o
);
   for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
      assign masked_o[e*NUM_EVT +: NUM_EVT] = st_i[e*NUM_EVT +: NUM_EVT] & mask_i;
      assign sum_o[e] = |masked_o[e*NUM_EVT +: NUM_EVT];
   end
   assign any_o = |sum_o;
endmodule

// File: rtl/iso_tracker.sv
module iso_tracker
   import ep_irq_pkg::*;
#(
   parameter int NDATA = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sof_i,
   input  logic [NDATA-1:0]   ep_en_i,
   input  logic [2*NDATA-1:0] ep_type_i,
   input  logic [NDATA-1:0]   xfer_done_i,
   output logic               miss_o
);
   logic [NDATA-1:0] done_q;
   logic [NDATA-1:0] lag;

   for (genvar d = 0; d < NDATA; d++) begin : g_ep
      always_ff @(posedge clk) begin
         if (!rst_n)              done_q[d] <= 1'b0;
         else if (xfer_done_i[d]) done_q[d] <= 1'b1;
         else if (sof_i)          done_q[d] <= 1'b0;
      end
      assign lag[d] = ep_en_i[d]
                    && (xfer_type_e'(ep_type_i[2*d +: 2]) == XT_ISOC)
                    && !(done_q[d] || xfer_done_i[d]);
   end
   assign miss_o = |lag;

   // R9
   sof_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sof_i |=> ((done_q & ~$past(xfer_done_i)) == '0));

   // R9
   done_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done_i != '0) |=> ((done_q & $past(xfer_done_i)) == $past(xfer_done_i)));
endmodule

// File: rtl/ep_irq_agg.sv
module ep_irq_agg
   import ep_irq_pkg::*;
#(
   parameter int NDATA = 5,
   parameter int NEVT  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [(NDATA+1)*NEVT-1:0] in_evt,
   input  logic [(NDATA+1)*NEVT-1:0] out_evt,
   input  logic [(NDATA+1)*NEVT-1:0] in_clr,
   input  logic [(NDATA+1)*NEVT-1:0] out_clr,
   input  logic [NEVT-1:0]           in_mask,
   input  logic [NEVT-1:0]           out_mask,
   input  logic [NDATA-1:0]          in_ep_en,
   input  logic [NDATA-1:0]          out_ep_en,
   input  logic [2*NDATA-1:0]        in_ep_type,
   input  logic [2*NDATA-1:0]        out_ep_type,
   input  logic [NDATA-1:0]          in_xfer_done,
   input  logic [NDATA-1:0]          out_xfer_done,
   input  logic                      sof,
   input  logic                      eof,
   input  logic [2:0]                flag_clr,
   output logic [(NDATA+1)*NEVT-1:0] in_status,
   output logic [(NDATA+1)*NEVT-1:0] out_status,
   output logic [NDATA:0]            in_ep_sum,
   output logic [NDATA:0]            out_ep_sum,
   output logic                      in_ep_irq,
   output logic                      out_ep_irq,
   output logic                      eopf_flag,
   output logic                      iso_in_incomp,
   output logic                      iso_out_incomp
);
   localparam int NEP = NDATA + 1;
   localparam int SW  = NEP * NEVT;

   if (NDATA < 1 || NDATA > 15) begin : g_bad_ndata
      $error("ep_irq_agg: NDATA must lie in 1..15");
   end
   if (NEVT < 1) begin : g_bad_nevt
      $error("ep_irq_agg: NEVT must be at least 1");
   end

   logic [SW-1:0]        in_raw, out_raw;
   logic                 in_miss, out_miss;
   logic [NUM_FLAGS-1:0] flag_set, flag_q;

   ep_stat_bank #(.W(SW)) u_in_bank (
      .clk(clk), .rst_n(rst_n), .set_i(in_evt), .clr_i(in_clr), .st_o(in_raw));
   ep_stat_bank #(.W(SW)) u_out_bank (
      .clk(clk), .rst_n(rst_n), .set_i(out_evt), .clr_i(out_clr), .st_o(out_raw));

   ep_summary #(.NUM_EP(NEP), .NUM_EVT(NEVT)) u_in_sum (
      .st_i(in_raw), .mask_i(in_mask), .masked_o(in_status),
      .sum_o(in_ep_sum), .any_o(in_ep_irq));
   ep_summary #(.NUM_EP(NEP), .NUM_EVT(NEVT)) u_out_sum (
      .st_i(out_raw), .mask_i(out_mask), .masked_o(out_status),
      .sum_o(out_ep_sum), .any_o(out_ep_irq));

   iso_tracker #(.NDATA(NDATA)) u_in_iso (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .ep_en_i(in_ep_en),
      .ep_type_i(in_ep_type), .xfer_done_i(in_xfer_done), .miss_o(in_miss));
   iso_tracker #(.NDATA(NDATA)) u_out_iso (
      .clk(clk), .rst_n(rst_n), .sof_i(sof), .ep_en_i(out_ep_en),
      .ep_type_i(out_ep_type), .xfer_done_i(out_xfer_done), .miss_o(out_miss));

   always_comb begin
      flag_set               = '0;
      flag_set[FLAG_EOPF]    = eof;
      flag_set[FLAG_ISO_IN]  = eof & in_miss;
      flag_set[FLAG_ISO_OUT] = eof & out_miss;
   end

   ep_stat_bank #(.W(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .st_o(flag_q));

   assign eopf_flag      = flag_q[FLAG_EOPF];
   assign iso_in_incomp  = flag_q[FLAG_ISO_IN];
   assign iso_out_incomp = flag_q[FLAG_ISO_OUT];

   // R6
   iso_in_with_eopf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_in_incomp) |-> (eopf_flag && $past(eof)));

   // R7
   iso_out_with_eopf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(iso_out_incomp) |-> (eopf_flag && $past(eof)));

   // R5
   eopf_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eof |=> eopf_flag);

   // R4
   irq_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ep_irq) |-> (($past(in_clr) != '0) || ($past(in_mask) != in_mask)));
endmodule

// File: tb/ep_irq_agg_tb.sv
`timescale 1ns/1ps
module ep_irq_agg_tb;
   localparam int NDATA = 5;
   localparam int NEVT  = 4;
   localparam int NEP   = NDATA + 1;
   localparam int SW    = NEP * NEVT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SW-1:0] in_evt = '0, out_evt = '0, in_clr = '0, out_clr = '0;
   logic [NEVT-1:0] in_mask = '0, out_mask = '0;
   logic [NDATA-1:0] in_ep_en = '0, out_ep_en = '0, in_xfer_done = '0, out_xfer_done = '0;
   logic [2*NDATA-1:0] in_ep_type = '0, out_ep_type = '0;
   logic sof = 1'b0, eof = 1'b0;
   logic [2:0] flag_clr = '0;

   logic [SW-1:0] in_status, out_status;
   logic [NDATA:0] in_ep_sum, out_ep_sum;
   logic in_ep_irq, out_ep_irq, eopf_flag, iso_in_incomp, iso_out_incomp;

   int checks = 0;
   int errors = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   ep_irq_agg #(.NDATA(NDATA), .NEVT(NEVT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_evt(in_evt), .out_evt(out_evt), .in_clr(in_clr), .out_clr(out_clr),
      .in_mask(in_mask), .out_mask(out_mask),
      .in_ep_en(in_ep_en), .out_ep_en(out_ep_en),
      .in_ep_type(in_ep_type), .out_ep_type(out_ep_type),
      .in_xfer_done(in_xfer_done), .out_xfer_done(out_xfer_done),
      .sof(sof), .eof(eof), .flag_clr(flag_clr),
      .in_status(in_status), .out_status(out_status),
      .in_ep_sum(in_ep_sum), .out_ep_sum(out_ep_sum),
      .in_ep_irq(in_ep_irq), .out_ep_irq(out_ep_irq),
      .eopf_flag(eopf_flag), .iso_in_incomp(iso_in_incomp),
      .iso_out_incomp(iso_out_incomp));

   // Behavioural reference state
   bit m_in_st[SW], m_out_st[SW];
   bit m_in_done[NDATA], m_out_done[NDATA];
   bit m_eopf, m_iso_in, m_iso_out;

   function automatic bit late(input bit en, input logic [1:0] ty, input bit dn, input bit now);
      return en && (ty == 2'b01) && !dn && !now;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_in_st[i]) begin m_in_st[i] = 0; m_out_st[i] = 0; end
         foreach (m_in_done[d]) begin m_in_done[d] = 0; m_out_done[d] = 0; end
         m_eopf = 0; m_iso_in = 0; m_iso_out = 0;
      end else begin
         bit mi, mo;
         mi = 0; mo = 0;
         for (int d = 0; d < NDATA; d++) begin
            if (late(in_ep_en[d], in_ep_type[2*d +: 2], m_in_done[d], in_xfer_done[d])) mi = 1;
            if (late(out_ep_en[d], out_ep_type[2*d +: 2], m_out_done[d], out_xfer_done[d])) mo = 1;
         end
         for (int i = 0; i < SW; i++) begin
            if (in_evt[i]) m_in_st[i] = 1; else if (in_clr[i]) m_in_st[i] = 0;
            if (out_evt[i]) m_out_st[i] = 1; else if (out_clr[i]) m_out_st[i] = 0;
         end
         for (int d = 0; d < NDATA; d++) begin
            if (in_xfer_done[d]) m_in_done[d] = 1; else if (sof) m_in_done[d] = 0;
            if (out_xfer_done[d]) m_out_done[d] = 1; else if (sof) m_out_done[d] = 0;
         end
         if (eof) m_eopf = 1; else if (flag_clr[0]) m_eopf = 0;
         if (eof && mi) m_iso_in = 1; else if (flag_clr[1]) m_iso_in = 0;
         if (eof && mo) m_iso_out = 1; else if (flag_clr[2]) m_iso_out = 0;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Compare every output against the model; called at the falling edge
   task automatic compare();
      logic [SW-1:0] ei, eo;
      logic [NEP-1:0] si, so;
      for (int e = 0; e < NEP; e++) begin
         si[e] = 0; so[e] = 0;
         for (int k = 0; k < NEVT; k++) begin
            ei[e*NEVT+k] = m_in_st[e*NEVT+k] & in_mask[k];
            eo[e*NEVT+k] = m_out_st[e*NEVT+k] & out_mask[k];
            si[e] = si[e] | ei[e*NEVT+k];
            so[e] = so[e] | eo[e*NEVT+k];
         end
      end
      chk("R1/R2/R3 in_status", 64'(in_status), 64'(ei));
      chk("R1/R2/R3 out_status", 64'(out_status), 64'(eo));
      chk("R4 in_ep_sum", 64'(in_ep_sum), 64'(si));
      chk("R4 out_ep_sum", 64'(out_ep_sum), 64'(so));
      chk("R4 irq", 64'({in_ep_irq, out_ep_irq}), 64'({|si, |so}));
      chk("R5/R10 eopf_flag", 64'(eopf_flag), 64'(m_eopf));
      chk("R6/R8/R9 iso_in_incomp", 64'(iso_in_incomp), 64'(m_iso_in));
      chk("R7/R8/R9 iso_out_incomp", 64'(iso_out_incomp), 64'(m_iso_out));
   endtask

   task automatic quiet();
      in_evt = '0; out_evt = '0; in_clr = '0; out_clr = '0;
      in_xfer_done = '0; out_xfer_done = '0; sof = 0; eof = 0; flag_clr = '0;
   endtask

   task automatic step();
      @(negedge clk);
      compare();
      quiet();
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      in_mask = '1; out_mask = '1;
      #0;
      chk("R1 reset in_status", 64'(in_status), 64'd0);
      chk("R1 reset flags", 64'({eopf_flag, iso_in_incomp, iso_out_incomp}), 64'd0);

      // R1/R3: endpoint 0 event 2 latched, hidden by mask, revealed again
      in_evt = SW'(1) << 2;
      step();
      in_mask = 4'b1011;
      step();
      chk("R3 masked hides", 64'(in_status), 64'd0);
      in_mask = 4'b1111;
      step();
      chk("R3 unmask reveals", 64'(in_status), 64'h4);
      chk("R4 ep0 summary", 64'(in_ep_sum), 64'h1);

      // R2: set wins over clear in the same cycle
      in_evt = SW'(1) << 2; in_clr = SW'(1) << 2;
      step();
      chk("R2 set wins", 64'(in_status[2]), 64'd1);
      in_clr = SW'(1) << 2;
      step();
      chk("R2 clear", 64'(in_status[2]), 64'd0);

      // R8: only bulk/interrupt/control or disabled-iso endpoints -> no flag
      in_ep_type = {2'b10, 2'b11, 2'b00, 2'b10, 2'b01};
      in_ep_en   = 5'b11110;
      sof = 1;
      step();
      eof = 1;
      step();
      step();
      chk("R8 ignored types", 64'(iso_in_incomp), 64'd0);
      chk("R5 eopf set", 64'(eopf_flag), 64'd1);

      // R9: enabled iso endpoint 1 completing within the frame -> no flag
      in_ep_en = 5'b11111; flag_clr = 3'b111;
      sof = 1;
      step();
      in_xfer_done = 5'b00001;
      step();
      eof = 1;
      step();
      step();
      chk("R9 completed iso", 64'(iso_in_incomp), 64'd0);
      // R9: new frame erases completion -> flag with eopf (R6)
      sof = 1; flag_clr = 3'b001;
      step();
      eof = 1;
      step();
      step();
      chk("R6 iso_in_incomp", 64'(iso_in_incomp), 64'd1);
      chk("R6 together eopf", 64'(eopf_flag), 64'd1);
      // R9: completion in the eof cycle counts
      flag_clr = 3'b111; sof = 1;
      step();
      eof = 1; in_xfer_done = 5'b00001;
      step();
      step();
      chk("R9 done with eof", 64'(iso_in_incomp), 64'd0);

      // R7: OUT direction iso endpoint 5
      out_ep_type = {2'b01, 8'b10101010}; out_ep_en = 5'b10000;
      sof = 1;
      step();
      eof = 1;
      step();
      step();
      chk("R7 iso_out_incomp", 64'(iso_out_incomp), 64'd1);
      // R10: flag set and clear together -> set
      eof = 1; flag_clr = 3'b001;
      step();
      step();
      chk("R10 set wins", 64'(eopf_flag), 64'd1);

      // Randomised traffic compared cycle by cycle
      for (int c = 0; c < 6000; c++) begin
         @(negedge clk);
         compare();
         quiet();
         if (c % 200 == 0) begin
            in_ep_type = 10'($urandom); out_ep_type = 10'($urandom);
            in_ep_en = 5'($urandom); out_ep_en = 5'($urandom);
         end
         if (c % 37 == 0) begin in_mask = 4'($urandom); out_mask = 4'($urandom); end
         in_evt  = SW'($urandom & $urandom & $urandom);
         out_evt = SW'($urandom & $urandom & $urandom);
         in_clr  = SW'($urandom & $urandom);
         out_clr = SW'($urandom & $urandom);
         in_xfer_done  = 5'($urandom & $urandom & $urandom);
         out_xfer_done = 5'($urandom & $urandom & $urandom);
         sof = (c % 20 == 0) || ($urandom_range(0, 40) == 0);
         eof = (c % 20 == 15) || ($urandom_range(0, 40) == 0);
         flag_clr = ($urandom_range(0, 5) == 0) ? 3'($urandom) : 3'b000;
      end
      step();
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule